// File: doc/BRIEF.md
# PRBS7 Word Injector with Loopback Checker

This block sits between a transmit line encoder and the serializer. When link test mode is off, the 20-bit encoded word moves through to the serializer unchanged, one word per word clock. When test mode is on, the block ignores the encoded word. In its place it sends successive 20-bit slices of a 2^7-1 pseudorandom bit sequence, generated by the polynomial x^7 + x^6 + 1. Because the pattern enters after the encoder, it reaches the line without any 8b/10b encoding applied.

A companion checker takes a received 20-bit word each clock, for example over a loopback path. It seeds itself from the first seven bits it sees after it is armed. It then predicts every later bit with its own free-running generator, counts mismatches in a saturating counter, and raises a lock flag once enough clean bits have passed in a row. Mode changes only take effect at a word clock edge, so a word is never part pattern and part data.

Top module: `prbs_word_injector`

## Requirements
- R1: While reset is asserted, the outputs are as follows: txWord is 0, chkLock is 0, chkErrCount is 0, and the generator state is all ones.
- R2: When testEn is low at a clock edge, txWord after that edge equals the encWord sampled at that edge.
- R3: When testEn is high at consecutive edges, txWord carries consecutive 20-bit slices of the sequence b[n] = b[n-6] XOR b[n-7]. The seven bits before b[0] are taken as 1. Bit 0 of each word is the earliest bit. The sequence repeats every 127 bits.
- R4: While testEn is high, the value of encWord has no effect on txWord.
- R5: testEn is only sampled at word clock edges. Each edge with testEn low puts the generator back at its seed, so the first pattern word after testEn returns high is again b[0..19].
- R6: The generator state is never all zeros.
- R7: While chkEn is low at an edge, the checker clears its count and lock. After chkEn goes high, the first 7 received bits (rxWord bit 0 first) are taken as the seed and are not compared. The seed may come from any phase of the sequence.
- R8: Every received bit after the seed is compared with the checker's own prediction, and each mismatch adds one to chkErrCount. A single flipped bit counts exactly once.
- R9: chkErrCount saturates at 65535 and holds there.
- R10: chkLock is high after a word that ends a run of at least 20 consecutive matching compared bits. A mismatch clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low reset |
| testEn | input | 1 | Selects the pseudorandom pattern instead of encoded data |
| encWord | input | 20 | Encoded word from the line encoder |
| txWord | output | 20 | Word to the serializer, bit 0 sent first |
| chkEn | input | 1 | Checker enable; low re-arms the checker |
| rxWord | input | 20 | Received word for checking, bit 0 earliest |
| chkLock | output | 1 | Checker has seen 20 or more clean bits in a row |
| chkErrCount | output | 16 | Saturating count of mismatched bits |

## Verification
The bench compares 131 pattern words against a sequence it builds itself, so the run crosses the 127-bit wrap. A wrong tap, a reversed bit order inside the word, or a missing seed would show up at the first word. When test mode is left and re-entered, the pattern must restart at b[0]; a generator that kept running would show a phase shift. One flipped bit in loopback must count exactly once and must drop lock for one word; a checker that resynchronized on received bits would count three. The bench also feeds words with every bit inverted until the count passes 65535, so a counter that wrapped would read a small value.

// File: rtl/prbs_inj_pkg.sv
package prbs_inj_pkg;

  // Strobes from control to datapath, valid for the current word clock edge.
  typedef struct packed {
    logic selGen;   // route generator word to the serializer
    logic stepGen;  // advance generator by one word
    logic seedGen;  // return generator to its all-ones seed
    logic armChk;   // clear checker and wait for a new seed
    logic runChk;   // checker consumes rxWord this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/prbs_inj_ctrl.sv
module prbs_inj_ctrl
  import prbs_inj_pkg::*;
(
  input  logic         testEn,
  input  logic         chkEn,
  output ctrlStrobes_t strobes
);

  // All strobes are consumed by flops, so a level change on an enable acts
  // only at the next word edge and never splits a word.
  always_comb begin
    strobes.selGen  = testEn;
    strobes.stepGen = testEn;
    strobes.seedGen = !testEn;
    strobes.armChk  = !chkEn;
    strobes.runChk  = chkEn;
  end

endmodule

// File: rtl/prbs_inj_gen.sv
module prbs_inj_gen
  import prbs_inj_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int ORDER  = 7,
  parameter int TAP_A  = 7,
  parameter int TAP_B  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] encWord,
  output logic [WORD_W-1:0] txWord,
  output logic [ORDER-1:0]  genState
);

  localparam logic [ORDER-1:0] SEED = {ORDER{1'b1}};

  logic [ORDER-1:0]  lfsrQ;
  logic [ORDER-1:0]  lfsrStep;
  logic [ORDER-1:0]  walk;
  logic [WORD_W-1:0] genWord;
  logic              fb;
  logic [WORD_W-1:0] txQ;

  // Unroll WORD_W single-bit steps; state bit 0 holds the newest bit.
  always_comb begin
    walk    = lfsrQ;
    genWord = '0;
    fb      = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      fb         = walk[TAP_A-1] ^ walk[TAP_B-1];
      genWord[i] = fb;
      walk       = {walk[ORDER-2:0], fb};
    end
    lfsrStep = walk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= SEED;
      txQ   <= '0;
    end else begin
      if (strobes.seedGen)      lfsrQ <= SEED;
      else if (strobes.stepGen) lfsrQ <= lfsrStep;
      txQ <= strobes.selGen ? genWord : encWord;
    end
  end

  assign txWord   = txQ;
  assign genState = lfsrQ;

endmodule

// File: rtl/prbs_inj_chk.sv
module prbs_inj_chk
  import prbs_inj_pkg::*;
#(
  parameter int WORD_W   = 20,
  parameter int ORDER    = 7,
  parameter int TAP_A    = 7,
  parameter int TAP_B    = 6,
  parameter int ERR_W    = 16,
  parameter int LOCK_RUN = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] rxWord,
  output logic              chkLock,
  output logic [ERR_W-1:0]  chkErrCount
);

  localparam int FILL_W = $clog2(ORDER + 1);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(ORDER);
  localparam logic [RUN_W-1:0]  RUN_FULL  = RUN_W'(LOCK_RUN);
  localparam logic [ERR_W-1:0]  ERR_MAX   = {ERR_W{1'b1}};

  logic [ORDER-1:0]  stQ,   stNext;
  logic [FILL_W-1:0] fillQ, fillNext;
  logic [RUN_W-1:0]  runQ,  runNext;
  logic [ERR_W-1:0]  errQ,  errNext;
  logic              lockQ;
  logic              pred;
  logic              miss;

  // Seed from the first ORDER received bits, then predict with a local
  // generator that does not feed back received bits.
  always_comb begin
    stNext   = stQ;
    fillNext = fillQ;
    runNext  = runQ;
    errNext  = errQ;
    pred     = 1'b0;
    miss     = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (fillNext < FILL_FULL) begin
        stNext   = {stNext[ORDER-2:0], rxWord[i]};
        fillNext = fillNext + FILL_W'(1);
      end else begin
        pred   = stNext[TAP_A-1] ^ stNext[TAP_B-1];
        miss   = rxWord[i] ^ pred;
        stNext = {stNext[ORDER-2:0], pred};
        if (miss) begin
          runNext = '0;
          if (errNext != ERR_MAX) errNext = errNext + ERR_W'(1);
        end else if (runNext < RUN_FULL) begin
          runNext = runNext + RUN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= '0;
      fillQ <= '0;
      runQ  <= '0;
      errQ  <= '0;
      lockQ <= 1'b0;
    end else if (strobes.armChk) begin
      stQ   <= '0;
      fillQ <= '0;
      runQ  <= '0;
      errQ  <= '0;
      lockQ <= 1'b0;
    end else if (strobes.runChk) begin
      stQ   <= stNext;
      fillQ <= fillNext;
      runQ  <= runNext;
      errQ  <= errNext;
      lockQ <= (runNext == RUN_FULL);
    end
  end

  assign chkLock     = lockQ;
  assign chkErrCount = errQ;

endmodule

// File: rtl/prbs_inj_datapath.sv
module prbs_inj_datapath
  import prbs_inj_pkg::*;
#(
  parameter int WORD_W   = 20,
  parameter int ORDER    = 7,
  parameter int TAP_A    = 7,
  parameter int TAP_B    = 6,
  parameter int ERR_W    = 16,
  parameter int LOCK_RUN = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] encWord,
  output logic [WORD_W-1:0] txWord,
  output logic [ORDER-1:0]  genState,
  input  logic [WORD_W-1:0] rxWord,
  output logic              chkLock,
  output logic [ERR_W-1:0]  chkErrCount
);

  prbs_inj_gen #(
    .WORD_W(WORD_W), .ORDER(ORDER), .TAP_A(TAP_A), .TAP_B(TAP_B)
  ) u_gen (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .encWord(encWord), .txWord(txWord), .genState(genState)
  );

  prbs_inj_chk #(
    .WORD_W(WORD_W), .ORDER(ORDER), .TAP_A(TAP_A), .TAP_B(TAP_B),
    .ERR_W(ERR_W), .LOCK_RUN(LOCK_RUN)
  ) u_chk (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rxWord(rxWord), .chkLock(chkLock), .chkErrCount(chkErrCount)
  );

endmodule

// File: rtl/prbs_word_injector.sv
module prbs_word_injector
  import prbs_inj_pkg::*;
#(
  parameter int WORD_W   = 20,
  parameter int ORDER    = 7,
  parameter int TAP_A    = 7,
  parameter int TAP_B    = 6,
  parameter int ERR_W    = 16,
  parameter int LOCK_RUN = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEn,
  input  logic [WORD_W-1:0] encWord,
  output logic [WORD_W-1:0] txWord,
  input  logic              chkEn,
  input  logic [WORD_W-1:0] rxWord,
  output logic              chkLock,
  output logic [ERR_W-1:0]  chkErrCount
);

  ctrlStrobes_t     strobes;
  logic [ORDER-1:0] genState;

  prbs_inj_ctrl u_ctrl (
    .testEn(testEn), .chkEn(chkEn), .strobes(strobes)
  );

  prbs_inj_datapath #(
    .WORD_W(WORD_W), .ORDER(ORDER), .TAP_A(TAP_A), .TAP_B(TAP_B),
    .ERR_W(ERR_W), .LOCK_RUN(LOCK_RUN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .encWord(encWord), .txWord(txWord), .genState(genState),
    .rxWord(rxWord), .chkLock(chkLock), .chkErrCount(chkErrCount)
  );

endmodule

// File: rtl/prbs_word_injector_sva.sv
module prbs_word_injector_sva #(
  parameter int WORD_W = 20,
  parameter int ORDER  = 7,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              testEn,
  input logic [WORD_W-1:0] encWord,
  input logic [WORD_W-1:0] txWord,
  input logic              chkEn,
  input logic              chkLock,
  input logic [ERR_W-1:0]  chkErrCount,
  input logic [ORDER-1:0]  genState
);

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |=> (txWord == $past(encWord)));

  assert_reseed_R5: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |=> (genState == {ORDER{1'b1}}));

  assert_state_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    genState != '0);

  assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    !chkEn |=> (chkErrCount == '0 && !chkLock));

  assert_count_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    chkEn |=> (chkErrCount >= $past(chkErrCount)));

  assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && chkErrCount == {ERR_W{1'b1}}) |=> (chkErrCount == {ERR_W{1'b1}}));

  assert_lock_clean_R10: assert property (@(posedge clk) disable iff (!rstN)
    chkLock |-> $stable(chkErrCount));

endmodule

bind prbs_word_injector prbs_word_injector_sva #(
  .WORD_W(WORD_W), .ORDER(ORDER), .ERR_W(ERR_W)
) u_sva (
  .clk(clk), .rstN(rstN), .testEn(testEn), .encWord(encWord),
  .txWord(txWord), .chkEn(chkEn), .chkLock(chkLock),
  .chkErrCount(chkErrCount), .genState(genState)
);

// File: tb/prbs_word_injector_bench.sv
module prbs_word_injector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WW = 20;
  localparam int PLEN = 127;

  logic          clk = 1'b0;
  logic          rstN;
  logic          testEn;
  logic [WW-1:0] encWord;
  logic [WW-1:0] txWord;
  logic          chkEn;
  logic [WW-1:0] rxWord;
  logic          chkLock;
  logic [15:0]   chkErrCount;

  logic          loopOn;
  logic [WW-1:0] flipMask;
  logic [WW-1:0] rxDrive;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  logic refArr [0:PLEN+6];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rxWord = loopOn ? (txWord ^ flipMask) : rxDrive;

  prbs_word_injector u_prbs_word_injector (
    .clk(clk), .rstN(rstN), .testEn(testEn), .encWord(encWord),
    .txWord(txWord), .chkEn(chkEn), .rxWord(rxWord),
    .chkLock(chkLock), .chkErrCount(chkErrCount)
  );

  // b[n] lives at refArr[n+7]; the seven earlier bits are ones.
  function automatic logic refBit(input int n);
    return refArr[(n % PLEN) + 7];
  endfunction

  function automatic logic [WW-1:0] seqWord(input int k);
    logic [WW-1:0] w;
    for (int i = 0; i < WW; i++) w[i] = refBit(WW * k + i);
    return w;
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1 txWord", 32'(txWord), 0);
    checkEq("R1 chkLock", 32'(chkLock), 0);
    checkEq("R1 chkErrCount", 32'(chkErrCount), 0);
    rstN = 1'b1;
  endtask

  task automatic testBypass();
    encWord = 20'hA5C3E;
    @(negedge clk);
    checkEq("R2 bypass a", 32'(txWord), 32'h000A5C3E);
    encWord = 20'h0F0F1;
    @(negedge clk);
    checkEq("R2 bypass b", 32'(txWord), 32'h0000F0F1);
  endtask

  task automatic testPattern();
    testEn = 1'b1;
    for (int k = 0; k < 131; k++) begin
      @(negedge clk);
      if (k < 2) checkEq("R4 encWord ignored", 32'(txWord), 32'(seqWord(k)));
      else       checkEq("R3 pattern word", 32'(txWord), 32'(seqWord(k)));
      encWord = WW'(k * 32'h9E37 + 32'h1357);
    end
  endtask

  task automatic testSwitch();
    testEn  = 1'b0;
    encWord = 20'hABCDE;
    @(negedge clk);
    checkEq("R5 leave test mode", 32'(txWord), 32'h000ABCDE);
    testEn = 1'b1;
    @(negedge clk);
    checkEq("R5 restart word0", 32'(txWord), 32'(seqWord(0)));
    @(negedge clk);
    checkEq("R5 restart word1", 32'(txWord), 32'(seqWord(1)));
  endtask

  task automatic testLoopback();
    loopOn = 1'b1;
    @(negedge clk);
    chkEn = 1'b1;
    @(negedge clk);
    checkEq("R7 seed lock", 32'(chkLock), 0);
    checkEq("R7 seed count", 32'(chkErrCount), 0);
    @(negedge clk);
    checkEq("R10 locked", 32'(chkLock), 1);
    checkEq("R8 clean count", 32'(chkErrCount), 0);
    flipMask = 20'h00008;
    @(negedge clk);
    flipMask = '0;
    checkEq("R8 one flip", 32'(chkErrCount), 1);
    checkEq("R10 lock dropped", 32'(chkLock), 0);
    @(negedge clk);
    checkEq("R10 relock", 32'(chkLock), 1);
    checkEq("R8 count held", 32'(chkErrCount), 1);
    chkEn = 1'b0;
    @(negedge clk);
    checkEq("R7 rearm count", 32'(chkErrCount), 0);
    checkEq("R7 rearm lock", 32'(chkLock), 0);
    loopOn = 1'b0;
  endtask

  task automatic testSaturate();
    rxDrive = seqWord(5);
    chkEn   = 1'b1;
    @(negedge clk);
    checkEq("R7 midphase seed", 32'(chkErrCount), 0);
    for (int j = 1; j <= 3280; j++) begin
      rxDrive = ~seqWord(5 + j);
      @(negedge clk);
      if (j == 1)    checkEq("R8 inverted word", 32'(chkErrCount), 20);
      if (j == 1)    checkEq("R10 no lock", 32'(chkLock), 0);
      if (j == 3276) checkEq("R9 below max", 32'(chkErrCount), 65520);
      if (j == 3277) checkEq("R9 saturated", 32'(chkErrCount), 65535);
      if (j == 3280) checkEq("R9 held", 32'(chkErrCount), 65535);
    end
    chkEn = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < 7; n++) refArr[n] = 1'b1;
    for (int n = 0; n < PLEN; n++) refArr[n + 7] = refArr[n + 1] ^ refArr[n];
    rstN = 1'b0; testEn = 1'b0; chkEn = 1'b0; encWord = '0;
    loopOn = 1'b0; flipMask = '0; rxDrive = '0;
    repeat (2) @(negedge clk);
    testReset();
    testBypass();
    testPattern();
    testSwitch();
    testLoopback();
    testSaturate();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule